// File: doc/BRIEF.md
# Base-Victim Compressed Cache Set Controller

This block controls one set of a compressed last-level cache. Every physical data way holds two tags that are fixed to its slot. The primary tag belongs to a baseline partition, and the secondary tag belongs to a victim partition. The baseline partition behaves exactly like an ordinary set-associative cache with true LRU replacement. The victim partition keeps lines that the baseline has evicted. It stores them in whatever space the baseline line leaves free in the same slot. Line sizes are counted in 8-byte segments, from 1 to 8. Two lines can share a slot when their sizes add up to 8 segments or fewer.

A request carries a tag, the compressed size of the line and a write flag. The controller compares the tag against both partitions in parallel and reports a baseline hit, a victim hit, or a miss, together with the way. It then carries out the sequence the result calls for:
- On a baseline hit, it updates the LRU order.
- On a victim hit, it swaps the hit line with the baseline LRU line.
- On a miss, it fetches the line through a fill command and installs it in the baseline.

Any write-back goes out on a command channel with a valid/ready handshake. Only tag, size, valid, dirty and replacement state are modelled.

Top module: `bvc_set_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `fill_valid` and `wb_valid` are 0, and all tags in both partitions are invalid, so the first access to any tag is a miss.
- R2: Each request is compared against all baseline and victim tags of the set. A tag is valid in at most one partition. The response sets `rsp_hit_base` or `rsp_hit_vict` (never both) and gives the hit way on `rsp_way`.
- R3: A baseline hit issues no fill and no write-back. It makes the hit line most recently used, and a request with `req_write`=1 marks the line dirty. The controller is ready again in the cycle after the response.
- R4: A new baseline line goes into the lowest-numbered invalid baseline way. If there is none, it goes into the least recently used way. The sequence of baseline hits and misses equals that of a plain 4-way LRU cache fed the same tags.
- R5: A miss in both partitions issues exactly one fill command carrying the request tag. The fetched line, of size `req_size` and dirty when `req_write`=1, is installed in the baseline.
- R6: A valid line displaced from the baseline is offered to the victim partition. A way can take it when 8 minus that way's baseline size (8 if the baseline is invalid) is at least the line's size. Among fitting ways whose victim tag is empty, the lowest-numbered way wins. If all fitting ways hold a victim, one is chosen pseudo-randomly and replaced. If no way fits, the line is dropped.
- R7: A victim hit issues no fill. The hit line leaves the victim partition and is installed in the baseline in the same way as a fetched line, and the displaced baseline line is offered to the victim partition as in R6.
- R8: When a line enters baseline way w and does not fit together with the victim line already in way w (sizes summing to more than 8), that victim line is dropped. A slot never holds more than 8 segments.
- R9: A dirty baseline line that leaves the baseline causes exactly one write-back with its tag. Victim lines are always clean, so dropping or replacing them causes no write-back.
- R10: `fill_valid` and `wb_valid`, once raised, stay high with a stable tag until the matching ready is seen. No new request is accepted until the current sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_tag | input | TAG_W | Line tag of the request |
| req_size | input | 4 | Compressed line size in segments (1..8) |
| req_write | input | 1 | Request writes the line (marks it dirty) |
| rsp_valid | output | 1 | Lookup result valid (one cycle) |
| rsp_hit_base | output | 1 | Hit in the baseline partition |
| rsp_hit_vict | output | 1 | Hit in the victim partition |
| rsp_way | output | WAY_W | Way of the hit |
| fill_valid | output | 1 | Fill command to the lower level |
| fill_ready | input | 1 | Lower level accepts the fill (line delivered) |
| fill_tag | output | TAG_W | Tag to fetch |
| wb_valid | output | 1 | Write-back command to the lower level |
| wb_ready | input | 1 | Lower level accepts the write-back |
| wb_tag | output | TAG_W | Tag being written back |

## Verification
A corrupted LRU age shows up at the first miss after the set is full: the wrong way is displaced, so a later access that a plain LRU cache would hit reports a miss, or the reverse. A lost or duplicated victim entry shows up at the next access to that tag. That access reports a miss and fill where a victim hit was due, or a second tag matches. A wrong dirty bit shows up when the line is displaced, as a missing or extra write-back on that same request. Directed sequences are built so that each of these effects appears within a few requests of its cause.

// File: rtl/bvc_pkg.sv
package bvc_pkg;
  localparam int SEG_W     = 4;
  localparam int LINE_SEGS = 8;

  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_INST,
    ST_WB,
    ST_PLACE
  } st_t;

  // segments left in a slot beside its baseline line
  function automatic seg_t free_segs(input logic vld, input seg_t used);
    return vld ? seg_t'(LINE_SEGS) - used : seg_t'(LINE_SEGS);
  endfunction

  // two lines share one slot only if they add up to a full line or less
  function automatic logic pair_fits(input seg_t a, input seg_t b);
    return ({1'b0, a} + {1'b0, b}) <= (SEG_W+1)'(LINE_SEGS);
  endfunction
endpackage

// File: rtl/bvc_lookup.sv
module bvc_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0]            tag,
  input  logic [WAYS-1:0]             base_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  base_tag,
  input  logic [WAYS-1:0]             vict_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  vict_tag,
  output logic [WAYS-1:0]             base_match,
  output logic [WAYS-1:0]             vict_match,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign base_match[w] = base_vld[w] && (base_tag[w] == tag);
    assign vict_match[w] = vict_vld[w] && (vict_tag[w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (base_match[w] || vict_match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/bvc_lru.sv
module bvc_lru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch,
  input  logic [WAY_W-1:0]  touch_way,
  input  logic [WAYS-1:0]   base_vld,
  output logic [WAY_W-1:0]  repl_way
);
  // age 0 is most recent, WAYS-1 is least recent; ages stay a permutation
  logic [WAYS-1:0][WAY_W-1:0] age;
  logic [WAY_W-1:0]           touched_age;
  logic                       any_free;
  logic [WAY_W-1:0]           free_way;
  logic [WAY_W-1:0]           old_way;

  assign touched_age = age[touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age[i] <= WAY_W'(i);
    end else if (touch) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way)   age[i] <= '0;
        else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    old_way  = '0;
    for (int i = WAYS-1; i >= 0; i--) begin
      if (!base_vld[i]) begin
        any_free = 1'b1;
        free_way = WAY_W'(i);
      end
      if (age[i] == WAY_W'(WAYS-1)) old_way = WAY_W'(i);
    end
    repl_way = any_free ? free_way : old_way;
  end
endmodule

// File: rtl/bvc_vplace.sv
module bvc_vplace
  import bvc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]         base_vld,
  input  logic [WAYS-1:0][SEG_W-1:0] base_sz,
  input  logic [WAYS-1:0]         vict_vld,
  input  seg_t                    line_sz,
  input  logic [WAY_W-1:0]        rnd,
  output logic                    place_ok,
  output logic [WAY_W-1:0]        place_way
);
  logic [WAYS-1:0] fit;
  logic [WAYS-1:0] empty_fit;
  logic [WAY_W-1:0] empty_way;
  logic [WAY_W-1:0] rand_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_fit
    assign fit[w]       = free_segs(base_vld[w], base_sz[w]) >= line_sz;
    assign empty_fit[w] = fit[w] && !vict_vld[w];
  end

  always_comb begin
    empty_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (empty_fit[w]) empty_way = WAY_W'(w);
    end
  end

  // first fitting way at or after the random start point, wrapping
  always_comb begin
    logic [WAY_W-1:0] idx;
    rand_way = '0;
    for (int k = WAYS-1; k >= 0; k--) begin
      idx = rnd + WAY_W'(k);
      if (fit[idx]) rand_way = idx;
    end
  end

  assign place_ok  = |fit;
  assign place_way = (|empty_fit) ? empty_way : rand_way;
endmodule

// File: rtl/bvc_set_ctrl.sv
module bvc_set_ctrl
  import bvc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [SEG_W-1:0]  req_size,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit_base,
  output logic              rsp_hit_vict,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [TAG_W-1:0]  wb_tag
);
  st_t st;

  // per-way tag state: baseline and victim halves of each slot
  logic [WAYS-1:0]              base_vld;
  logic [WAYS-1:0]              base_dty;
  logic [WAYS-1:0][TAG_W-1:0]   base_tag;
  logic [WAYS-1:0][SEG_W-1:0]   base_sz;
  logic [WAYS-1:0]              vict_vld;
  logic [WAYS-1:0][TAG_W-1:0]   vict_tag;
  logic [WAYS-1:0][SEG_W-1:0]   vict_sz;

  // captured request and the line on its way into the baseline
  logic [TAG_W-1:0] q_tag;
  seg_t             q_sz;
  logic             q_wr;
  seg_t             n_sz;
  logic             n_dty;

  // line displaced from the baseline
  logic             e_vld;
  logic             e_dty;
  logic [TAG_W-1:0] e_tag;
  seg_t             e_sz;

  logic [7:0] lfsr;

  // named internal events
  logic [WAYS-1:0]  base_match;
  logic [WAYS-1:0]  vict_match;
  logic [WAY_W-1:0] hit_way;
  logic             look_base_hit;
  logic             look_vict_hit;
  logic             lru_touch;
  logic [WAY_W-1:0] lru_way;
  logic [WAY_W-1:0] repl_way;
  logic             place_ok;
  logic [WAY_W-1:0] place_way;
  logic             inst_evt;
  logic             place_evt;
  logic             vict_bump;

  bvc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_look (
    .tag        (q_tag),
    .base_vld   (base_vld),
    .base_tag   (base_tag),
    .vict_vld   (vict_vld),
    .vict_tag   (vict_tag),
    .base_match (base_match),
    .vict_match (vict_match),
    .hit_way    (hit_way)
  );

  assign look_base_hit = (st == ST_LOOK) && (|base_match);
  assign look_vict_hit = (st == ST_LOOK) && (|vict_match);
  assign inst_evt      = (st == ST_INST);
  assign place_evt     = (st == ST_PLACE) && place_ok;
  assign lru_touch     = look_base_hit || inst_evt;
  assign lru_way       = inst_evt ? repl_way : hit_way;

  bvc_lru #(.WAYS(WAYS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (lru_touch),
    .touch_way (lru_way),
    .base_vld  (base_vld),
    .repl_way  (repl_way)
  );

  bvc_vplace #(.WAYS(WAYS)) u_place (
    .base_vld  (base_vld),
    .base_sz   (base_sz),
    .vict_vld  (vict_vld),
    .line_sz   (e_sz),
    .rnd       (lfsr[WAY_W-1:0]),
    .place_ok  (place_ok),
    .place_way (place_way)
  );

  // incoming baseline line clashes with the victim already in its slot
  assign vict_bump = inst_evt && vict_vld[repl_way] &&
                     !pair_fits(n_sz, vict_sz[repl_way]);

  assign req_ready    = (st == ST_IDLE);
  assign rsp_valid    = (st == ST_LOOK);
  assign rsp_hit_base = look_base_hit;
  assign rsp_hit_vict = look_vict_hit;
  assign rsp_way      = hit_way;
  assign fill_valid   = (st == ST_FILL);
  assign fill_tag     = q_tag;
  assign wb_valid     = (st == ST_WB);
  assign wb_tag       = e_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h5a;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      base_vld <= '0;
      base_dty <= '0;
      base_tag <= '0;
      base_sz  <= '0;
      vict_vld <= '0;
      vict_tag <= '0;
      vict_sz  <= '0;
      q_tag    <= '0;
      q_sz     <= '0;
      q_wr     <= 1'b0;
      n_sz     <= '0;
      n_dty    <= 1'b0;
      e_vld    <= 1'b0;
      e_dty    <= 1'b0;
      e_tag    <= '0;
      e_sz     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            q_tag <= req_tag;
            q_sz  <= req_size;
            q_wr  <= req_write;
            st    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (|base_match) begin
            if (q_wr) base_dty[hit_way] <= 1'b1;
            st <= ST_IDLE;
          end else if (|vict_match) begin
            n_sz               <= vict_sz[hit_way];
            n_dty              <= q_wr;
            vict_vld[hit_way]  <= 1'b0;
            st                 <= ST_INST;
          end else begin
            st <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_ready) begin
            n_sz  <= q_sz;
            n_dty <= q_wr;
            st    <= ST_INST;
          end
        end
        ST_INST: begin
          e_vld              <= base_vld[repl_way];
          e_dty              <= base_dty[repl_way];
          e_tag              <= base_tag[repl_way];
          e_sz               <= base_sz[repl_way];
          base_vld[repl_way] <= 1'b1;
          base_dty[repl_way] <= n_dty;
          base_tag[repl_way] <= q_tag;
          base_sz[repl_way]  <= n_sz;
          if (vict_bump) vict_vld[repl_way] <= 1'b0;
          if (!base_vld[repl_way])     st <= ST_IDLE;
          else if (base_dty[repl_way]) st <= ST_WB;
          else                         st <= ST_PLACE;
        end
        ST_WB: begin
          if (wb_ready) begin
            e_dty <= 1'b0;
            st    <= ST_PLACE;
          end
        end
        ST_PLACE: begin
          if (place_ok && e_vld) begin
            vict_vld[place_way] <= 1'b1;
            vict_tag[place_way] <= e_tag;
            vict_sz[place_way]  <= e_sz;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bvc_set_chk.sv
module bvc_set_chk
  import bvc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      rsp_valid,
  input logic                      rsp_hit_base,
  input logic                      rsp_hit_vict,
  input logic                      fill_valid,
  input logic                      fill_ready,
  input logic [TAG_W-1:0]          fill_tag,
  input logic                      wb_valid,
  input logic                      wb_ready,
  input logic [TAG_W-1:0]          wb_tag,
  input logic [WAYS-1:0]           base_match,
  input logic [WAYS-1:0]           vict_match,
  input logic [WAYS-1:0]           base_vld,
  input logic [WAYS-1:0][SEG_W-1:0] base_sz,
  input logic [WAYS-1:0]           vict_vld,
  input logic [WAYS-1:0][SEG_W-1:0] vict_sz,
  input logic                      e_dty
);
  // R2: one partition, one way at most
  a_r2_one_partition: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({base_match, vict_match}));

  a_r2_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit_base && rsp_hit_vict));

  // R3: a baseline hit finishes straight after the response
  a_r3_base_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit_base) |=> req_ready);

  // R8: no slot is ever overfilled
  for (genvar w = 0; w < WAYS; w++) begin : g_slot
    a_r8_slot_fits: assert property (@(posedge clk) disable iff (!rst_n)
      vict_vld[w] |-> pair_fits(base_vld[w] ? base_sz[w] : seg_t'(0), vict_sz[w]));
  end

  // R9: write-backs only for lines that left the baseline dirty
  a_r9_wb_dirty_only: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> e_dty);

  // R10: commands hold until accepted; one sequence at a time
  a_r10_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_tag)));

  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag)));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind bvc_set_ctrl bvc_set_chk #(.WAYS(WAYS), .TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_hit_base (rsp_hit_base),
  .rsp_hit_vict (rsp_hit_vict),
  .fill_valid   (fill_valid),
  .fill_ready   (fill_ready),
  .fill_tag     (fill_tag),
  .wb_valid     (wb_valid),
  .wb_ready     (wb_ready),
  .wb_tag       (wb_tag),
  .base_match   (base_match),
  .vict_match   (vict_match),
  .base_vld     (base_vld),
  .base_sz      (base_sz),
  .vict_vld     (vict_vld),
  .vict_sz      (vict_sz),
  .e_dty        (e_dty)
);

// File: tb/sim_bvc_set_ctrl.sv
module sim_bvc_set_ctrl;
  localparam int WAYS  = 4;
  localparam int TAG_W = 16;
  localparam int WAY_W = $clog2(WAYS);
  localparam int NVEC  = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [TAG_W-1:0] req_tag = '0;
  logic [3:0]       req_size = '0;
  logic             req_write = 1'b0;
  logic             rsp_valid, rsp_hit_base, rsp_hit_vict;
  logic [WAY_W-1:0] rsp_way;
  logic             fill_valid;
  logic             fill_ready = 1'b1;
  logic [TAG_W-1:0] fill_tag;
  logic             wb_valid;
  logic             wb_ready = 1'b1;
  logic [TAG_W-1:0] wb_tag;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // result of the last request: kind 0 miss, 1 baseline hit, 2 victim hit
  int got_kind, got_way, got_fills, got_wbs, got_wbtag;

  always #10 clk = ~clk;

  bvc_set_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W)) u0 (.*);

  // stimulus table: tag, size, expected kind (plain LRU reasoning)
  localparam logic [15:0] V_TAG [NVEC] = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd1, 16'd5,
                                           16'd2, 16'd6, 16'd1, 16'd3, 16'd7, 16'd5};
  localparam int V_KIND [NVEC] = '{0, 0, 0, 0, 1, 0, 2, 0, 1, 2, 0, 2};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // issue one request; hold fill_ready low for `hold` negedges (R10)
  task automatic do_req(input int tag, input int sz, input bit wr, input int hold);
    int cnt;
    got_kind = -1; got_way = -1; got_fills = 0; got_wbs = 0; got_wbtag = -1;
    fill_ready = (hold == 0);
    req_tag = TAG_W'(tag); req_size = 4'(sz); req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1;
    forever begin
      if (hold > 0 && cnt == hold) fill_ready = 1'b1;
      if (hold > 0 && cnt >= 2 && cnt < hold)
        chk(fill_valid && fill_tag == TAG_W'(tag) && !req_ready,
            "R10 fill held while not ready", int'(fill_valid), 1);
      if (rsp_valid) begin
        got_kind = rsp_hit_base ? 1 : (rsp_hit_vict ? 2 : 0);
        got_way  = int'(rsp_way);
      end
      if (fill_valid && fill_ready) got_fills++;
      if (wb_valid && wb_ready) begin
        got_wbs++;
        got_wbtag = int'(wb_tag);
      end
      if (req_ready) break;
      @(negedge clk);
      cnt++;
    end
    fill_ready = 1'b1;
  endtask

  initial begin
    reset_dut();
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(fill_valid == 1'b0, "R1 no fill after reset", int'(fill_valid), 0);
    chk(wb_valid == 1'b0, "R1 no wb after reset", int'(wb_valid), 0);

    // table walk: R4 baseline behaves as plain LRU, R5 fill on miss, R7 swap
    for (int i = 0; i < NVEC; i++) begin
      do_req(int'(V_TAG[i]), 2, 1'b0, 0);
      chk(got_kind == V_KIND[i], "R4 R7 hit kind per vector", got_kind, V_KIND[i]);
      chk(got_fills == (V_KIND[i] == 0 ? 1 : 0), "R5 fill only on double miss",
          got_fills, V_KIND[i] == 0 ? 1 : 0);
      chk(got_wbs == 0, "R9 clean lines never written back", got_wbs, 0);
    end
    // first access after reset was a miss (R1)
    reset_dut();
    do_req(16'h99, 4, 1'b0, 0);
    chk(got_kind == 0, "R1 empty set misses", got_kind, 0);

    // R6/R7: eviction to lowest empty victim slot, then swap back
    reset_dut();
    for (int t = 0; t < 4; t++) do_req(16'h10 + t, 4, 1'b0, 0);
    do_req(16'h14, 4, 1'b0, 0);                  // A(0x10) displaced to victim way 0
    do_req(16'h10, 4, 1'b0, 0);
    chk(got_kind == 2, "R7 victim hit on displaced line", got_kind, 2);
    chk(got_way == 0, "R6 lowest empty victim way", got_way, 0);
    chk(got_fills == 0, "R7 swap issues no fill", got_fills, 0);
    do_req(16'h11, 4, 1'b0, 0);                  // B moved to victim way 0 by the swap
    chk(got_kind == 2 && got_way == 0, "R7 baseline LRU line moved to victim",
        got_kind * 10 + got_way, 20);
    do_req(16'h14, 4, 1'b1, 0);
    chk(got_kind == 1 && got_fills == 0, "R3 baseline hit no fill",
        got_kind * 10 + got_fills, 10);

    // R9: dirty line leaving the baseline is written back once
    reset_dut();
    do_req(16'h20, 4, 1'b1, 0);
    for (int t = 1; t < 4; t++) do_req(16'h20 + t, 4, 1'b0, 0);
    do_req(16'h24, 4, 1'b0, 0);
    chk(got_wbs == 1, "R9 one writeback for dirty line", got_wbs, 1);
    chk(got_wbtag == 16'h20, "R9 writeback tag", got_wbtag, 16'h20);
    do_req(16'h20, 4, 1'b0, 0);
    chk(got_kind == 2 && got_wbs == 0, "R9 written-back line kept clean in victim",
        got_kind * 10 + got_wbs, 20);

    // R3: write hit sets dirty, seen as a writeback when displaced
    reset_dut();
    for (int t = 0; t < 4; t++) do_req(16'h30 + t, 8, 1'b0, 0);
    do_req(16'h30, 8, 1'b1, 0);                  // hit, mark dirty; LRU now 0x31
    chk(got_kind == 1 && got_wbs == 0, "R3 write hit", got_kind * 10 + got_wbs, 10);
    do_req(16'h34, 8, 1'b0, 0);                  // displaces 0x31 (clean)
    chk(got_wbs == 0, "R4 LRU picks untouched line", got_wbs, 0);
    for (int t = 2; t < 4; t++) do_req(16'h30 + t, 8, 1'b0, 0);
    do_req(16'h35, 8, 1'b0, 0);                  // displaces dirty 0x30
    chk(got_wbs == 1 && got_wbtag == 16'h30, "R3 dirty from write hit", got_wbtag, 16'h30);

    // R8: baseline priority over victim sharing the slot
    reset_dut();
    for (int t = 0; t < 4; t++) do_req(16'h40 + t, 4, 1'b0, 0);
    do_req(16'h44, 4, 1'b0, 0);                  // 0x40 -> victim way 0
    for (int t = 1; t < 4; t++) do_req(16'h40 + t, 4, 1'b0, 0);
    do_req(16'h46, 6, 1'b0, 0);                  // lands in way 0, 6+4 > 8 drops 0x40
    chk(got_kind == 0 && got_wbs == 0, "R8 victim drop silent", got_kind * 10 + got_wbs, 0);
    do_req(16'h40, 4, 1'b0, 0);
    chk(got_kind == 0 && got_fills == 1, "R8 dropped victim line misses",
        got_kind * 10 + got_fills, 1);
    do_req(16'h44, 4, 1'b0, 0);
    chk(got_kind == 2 && got_way == 1, "R6 victim placed where it fits",
        got_kind * 10 + got_way, 21);

    // R10: fill held back by the lower level
    reset_dut();
    do_req(16'h50, 3, 1'b0, 6);
    chk(got_fills == 1, "R10 single fill after stall", got_fills, 1);
    do_req(16'h50, 3, 1'b0, 0);
    chk(got_kind == 1, "R5 stalled fill installed in baseline", got_kind, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule